// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block collects level interrupt requests from a set of identical banks, each serving 32 sources, and turns each bank into one interrupt line toward the processor. Each source input is latched into a sticky pending bit on every clock edge where it is high. Software clears a pending bit by writing a one to it. A per-bank enable vector decides which pending bits reach the bank's line. A priority encoder gives the number of the highest pending enabled source, so the handler does not have to scan the vector.

Software reaches each bank through its own window of five 32-bit registers on a simple register bus. The bus has no back-pressure. A write takes effect at the clock edge where it is presented. A read returns its data one cycle later, marked by a valid strobe. Bank n drives processor line n+2, and processor lines 0 and 1 are held low. The handler reads the index for the bank whose line is active, services that source, then clears its pending bit.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every register in every bank reads zero, every processor line is low and every index is zero.
- R2: Bank n's window starts at byte address n*0x28. Inside the window the registers sit at these offsets: pending 0x00, enable 0x08, masked view 0x10, resend 0x18, mask 0x20. Any other address reads zero, and a write to it changes nothing.
- R3: A source input that is high at a clock edge sets its pending bit. The bit stays set after the input falls.
- R4: Writing a one to a pending bit clears it, and writing a zero leaves it unchanged. If a source is high in the same cycle as a clear, the bit stays set.
- R5: The enable register is a read/write vector. Processor line n+2 is high exactly when bank n has at least one bit set in both pending and enable. The line follows the register update at the same edge.
- R6: The masked view at offset 0x10 reads pending AND enable, and reads zero when no enabled source is pending.
- R7: The bank index is the position of the most significant set bit of pending AND enable, and is zero when that vector is zero.
- R8: The resend and mask registers are read/write storage. Their contents have no effect on pending bits, lines or indices.
- R9: A read presented at a clock edge returns its data with rd_valid high in the following cycle. rd_valid is low in every other cycle. Processor lines 0 and 1 are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_BANKS*32 | Level source inputs; bank b uses bits [b*32 +: 32] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data strobe, one cycle after rd_en |
| cpu_irq | output | NUM_BANKS+2 | Processor lines; bit n+2 belongs to bank n, bits 1:0 are zero |
| irq_idx | output | NUM_BANKS*5 | Per-bank index of the highest pending enabled source |

## Verification
The assertions check four things on every cycle. A high source always leaves its pending bit set. A pending bit falls only when a clear was written. The index and the line agree with the pending and enable vectors. The read strobe trails the request by exactly one cycle. The bench scenarios show what the assertions cannot: the address decode across windows and the stride, the values read back, that a zero write has no effect, and that the resend and mask storage stays inert. They also cover the order of priority as sources at bits 5, 17 and 31 arrive and are cleared.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned SRC_W    = 32;
  localparam int unsigned IDX_W    = $clog2(SRC_W);
  localparam int unsigned WIN_SIZE = 'h28;
  localparam int unsigned OFF_W    = 6;

  typedef enum logic [OFF_W-1:0] {
    REG_PEND   = 6'h00,
    REG_ENABLE = 6'h08,
    REG_VIEW   = 6'h10,
    REG_RESEND = 6'h18,
    REG_MASK   = 6'h20
  } reg_off_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [SRC_W-1:0] pend_q,
  output logic [SRC_W-1:0] en_q,
  output logic [SRC_W-1:0] clr_mask,
  output logic             line,
  output logic [IDX_W-1:0] idx
);
  logic [SRC_W-1:0] resend_q, mask_q, active;

  assign clr_mask = (wr_en && off == REG_PEND) ? wdata[SRC_W-1:0] : '0;
  assign active   = pend_q & en_q;
  assign line     = |active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      en_q     <= '0;
      resend_q <= '0;
      mask_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | src;
      if (wr_en) begin
        unique case (off)
          REG_ENABLE: en_q     <= wdata[SRC_W-1:0];
          REG_RESEND: resend_q <= wdata[SRC_W-1:0];
          REG_MASK:   mask_q   <= wdata[SRC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (off)
      REG_PEND:   rdata = pend_q;
      REG_ENABLE: rdata = en_q;
      REG_VIEW:   rdata = active;
      REG_RESEND: rdata = resend_q;
      REG_MASK:   rdata = mask_q;
      default:    rdata = '0;
    endcase
  end

  irq_prio_enc #(.W(SRC_W), .IDX_W(IDX_W)) u_enc (
    .vec (active),
    .idx (idx)
  );
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*32-1:0]    irq_src,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wr_data,
  output logic [31:0]                rd_data,
  output logic                       rd_valid,
  output logic [NUM_BANKS+1:0]       cpu_irq,
  output logic [NUM_BANKS*5-1:0]     irq_idx
);
  localparam int unsigned ALL_W = NUM_BANKS * SRC_W;

  logic [NUM_BANKS-1:0]  hit;
  logic [NUM_BANKS-1:0]  line;
  logic [31:0]           bank_rd [NUM_BANKS];
  logic [ALL_W-1:0]      pend_all, en_all, clr_all;
  logic [31:0]           rd_mux;

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    localparam int unsigned BASE = b * WIN_SIZE;
    logic [ADDR_W-1:0] rel;
    assign rel    = addr - ADDR_W'(BASE);
    assign hit[b] = (32'(addr) >= BASE) && (32'(addr) < BASE + WIN_SIZE);

    irq_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (irq_src[b*SRC_W +: SRC_W]),
      .wr_en    (wr_en && hit[b]),
      .off      (rel[OFF_W-1:0]),
      .wdata    (wr_data),
      .rdata    (bank_rd[b]),
      .pend_q   (pend_all[b*SRC_W +: SRC_W]),
      .en_q     (en_all[b*SRC_W +: SRC_W]),
      .clr_mask (clr_all[b*SRC_W +: SRC_W]),
      .line     (line[b]),
      .idx      (irq_idx[b*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (hit[b]) rd_mux = rd_mux | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  assign cpu_irq = {line, 2'b00};
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_BANKS*32-1:0] src_all,
  input logic [NUM_BANKS*32-1:0] pend_all,
  input logic [NUM_BANKS*32-1:0] en_all,
  input logic [NUM_BANKS*32-1:0] clr_all,
  input logic [NUM_BANKS+1:0]    cpu_irq,
  input logic [NUM_BANKS*5-1:0]  irq_idx,
  input logic                    rd_en,
  input logic                    rd_valid
);
  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_chk
    logic [31:0] act;
    logic [4:0]  ix;
    assign act = pend_all[b*32 +: 32] & en_all[b*32 +: 32];
    assign ix  = irq_idx[b*5 +: 5];

    a_r3_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(src_all[b*32 +: 32]) & ~pend_all[b*32 +: 32]) == '0));

    a_r4_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_all[b*32 +: 32] & ~clr_all[b*32 +: 32]) & ~pend_all[b*32 +: 32]) == '0));

    a_r7_idx_highest: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[b+2] |-> ((act >> ix) == 32'd1));

    a_r5_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq[b+2] |-> (act == '0 && ix == '0));
  end

  a_r9_rd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_all  (irq_src),
  .pend_all (pend_all),
  .en_all   (en_all),
  .clr_all  (clr_all),
  .cpu_irq  (cpu_irq),
  .irq_idx  (irq_idx),
  .rd_en    (rd_en),
  .rd_valid (rd_valid)
);

// File: tb/irq_bank_ctrl_test.sv
`timescale 1ns/1ps
module irq_bank_ctrl_test;
  localparam int NB = 5;
  localparam int AW = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NB*32-1:0] irq_src = '0;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic             rd_valid;
  logic [NB+1:0]    cpu_irq;
  logic [NB*5-1:0]  irq_idx;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .cpu_irq(cpu_irq), .irq_idx(irq_idx)
  );

  function automatic logic [AW-1:0] ra(int bank, int off);
    return AW'(bank * 'h28 + off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check("R9 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic pulse_src(int bank, int bit_n);
    irq_src[bank*32 + bit_n] = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_src[bank*32 + bit_n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 lines", 32'(cpu_irq), 0);
    check("R1 idx", 32'(irq_idx), 0);
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, 'h00), d); check("R1 pending", d, 0);
      rd(ra(b, 'h08), d); check("R1 enable", d, 0);
    end
    @(negedge clk);
    check("R9 valid idle", 32'(rd_valid), 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    pulse_src(1, 5);
    rd(ra(1, 'h00), d); check("R3 sticky pending", d, 32'h20);
    check("R5 line gated by enable", 32'(cpu_irq), 0);
    rd(ra(1, 'h10), d); check("R6 view zero", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(ra(1, 'h08), 32'hFFFF_FFFF);
    check("R5 line bank1", 32'(cpu_irq), 32'h8);
    check("R7 idx 5", 32'(irq_idx[5 +: 5]), 5);
    rd(ra(1, 'h08), d); check("R5 enable rb", d, 32'hFFFF_FFFF);
    pulse_src(1, 17);
    check("R7 idx 17", 32'(irq_idx[5 +: 5]), 17);
    pulse_src(1, 31);
    check("R7 idx 31", 32'(irq_idx[5 +: 5]), 31);
    wr(ra(1, 'h08), 32'h0002_0000);
    rd(ra(1, 'h10), d); check("R6 view", d, 32'h0002_0000);
    check("R7 idx masked", 32'(irq_idx[5 +: 5]), 17);
    wr(ra(1, 'h08), 32'hFFFF_FFFF);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(ra(1, 'h00), 32'h0);
    rd(ra(1, 'h00), d); check("R4 zero write", d, 32'h8002_0020);
    wr(ra(1, 'h00), 32'h8000_0000);
    rd(ra(1, 'h00), d); check("R4 w1c", d, 32'h0002_0020);
    check("R7 idx after clear", 32'(irq_idx[5 +: 5]), 17);
    irq_src[32 + 17] = 1'b1;
    wr(ra(1, 'h00), 32'h0002_0000);
    irq_src[32 + 17] = 1'b0;
    rd(ra(1, 'h00), d); check("R4 set wins", d, 32'h0002_0020);
    wr(ra(1, 'h00), 32'hFFFF_FFFF);
    check("R5 line drops", 32'(cpu_irq), 0);
    check("R7 idx zero", 32'(irq_idx), 0);
    rd(ra(1, 'h10), d); check("R6 view empty", d, 0);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    pulse_src(3, 9);
    wr(ra(3, 'h20), 32'hFFFF_FFFF);
    wr(ra(3, 'h18), 32'hA5A5_0F0F);
    rd(ra(3, 'h20), d); check("R8 mask rb", d, 32'hFFFF_FFFF);
    rd(ra(3, 'h18), d); check("R8 resend rb", d, 32'hA5A5_0F0F);
    rd(ra(3, 'h00), d); check("R8 pending untouched", d, 32'h200);
    check("R8 line untouched", 32'(cpu_irq), 0);
    wr(ra(3, 'h08), 32'h200);
    check("R8 mask no effect", 32'(cpu_irq), 32'h20);
    check("R7 idx bank3", 32'(irq_idx[15 +: 5]), 9);
  endtask

  task automatic t_windows();
    logic [31:0] d;
    wr(ra(4, 'h08), 32'h1);
    rd(ra(4, 'h08), d); check("R2 bank4 enable", d, 32'h1);
    rd(ra(3, 'h08), d); check("R2 bank3 isolated", d, 32'h200);
    pulse_src(4, 0);
    check("R5 line n+2", 32'(cpu_irq), 32'h60);
    check("R9 low lines", 32'(cpu_irq[1:0]), 0);
    wr(ra(0, 'h04), 32'hFFFF_FFFF);
    rd(ra(0, 'h04), d); check("R2 hole reads zero", d, 0);
    rd(ra(0, 'h08), d); check("R2 hole write ignored", d, 0);
    wr(AW'(NB * 'h28 + 8), 32'hFFFF_FFFF);
    rd(AW'(NB * 'h28 + 8), d); check("R2 beyond windows", d, 0);
    check("R2 lines unchanged", 32'(cpu_irq), 32'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_enable();
    t_clear();
    t_storage();
    t_windows();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule